// File: doc/BRIEF.md
# External Bus Strobe and Lane Controller

The block turns an internal memory request into one or two cycles on an external 16-bit data bus. The bus is split into an upper lane (bits 15..8) and a lower lane (bits 7..0). The address space is divided into eight areas, and each area is configured as 8 bits wide or 16 bits wide through one bit per area. For each request the block decodes the area and pulls that area's chip select low. It drives a single read strobe, or one write strobe per lane. It places write data on the correct lane and collects read data from the correct lane.

Every bus cycle has the same three states. In the first, the address and chip select are driven. In the second and third, the strobe is held low. Read data is sampled at the end of the third state. When a 16-bit word goes to an 8-bit area, the block splits it into two byte cycles on the upper lane. The requester sees a request/acknowledge handshake: it raises `req_i` with the address, size, direction and write data, and holds them until `ack_o` pulses.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While a cycle is in its three states, exactly the addressed area's chip select is low. Area index = address bits 23..21. Outside those states, all chip selects are high.
- R2: When `large_mode_i` is 0, area 0 covers only its first 128 KB (address bits 20..17 zero). An area-0 access above that runs the cycle with no chip select low. When `large_mode_i` is 1, area 0 covers the whole 2 MB.
- R3: A read lowers only `bus_rd_no`, which covers both lanes. No write strobe falls and `bus_d_oe_o` stays low.
- R4: In an 8-bit area (`area_wide_i` bit = 0), a byte access uses only the upper lane. A write lowers only `bus_hwr_no`, and the data byte (`wdata_i[7:0]`) appears on bits 15..8.
- R5: In a 16-bit area, a byte at an even address uses the upper lane and `bus_hwr_no`. A byte at an odd address uses the lower lane and `bus_lwr_no`.
- R6: A word access to a 16-bit area uses one cycle at the even address. A write lowers both write strobes together and drives `wdata_i[15:8]` on the upper lane and `wdata_i[7:0]` on the lower lane.
- R7: A word access to an 8-bit area runs two upper-lane cycles, first at the even address with the high byte and then at the odd address with the low byte. It is acknowledged only after the second cycle.
- R8: A request seen at a clock edge starts state 1 at that edge. The strobe is low for exactly the two following states. `ack_o` is high for one cycle right after the last state 3, with all strobes high.
- R9: Read data is sampled from the used lane(s) at the end of state 3. A byte read returns the byte in `rdata_o[7:0]` with bits 15..8 zero, and the unused lane is ignored. A word read returns the even-address byte in bits 15..8.
- R10: After reset, all chip selects and strobes are high, `ack_o` is low and the data drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, held until acknowledge |
| ack_o | output | 1 | One-cycle completion pulse |
| addr_i | input | 24 | Byte address |
| word_i | input | 1 | 1 = word, 0 = byte |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 16 | Write data (byte in bits 7..0) |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| area_wide_i | input | 8 | Per-area width, 1 = 16-bit |
| large_mode_i | input | 1 | Selects the 2 MB area-0 span |
| bus_addr_o | output | 24 | External address |
| bus_cs_no | output | 8 | Per-area chip selects, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_hwr_no | output | 1 | Upper-lane write strobe, active low |
| bus_lwr_no | output | 1 | Lower-lane write strobe, active low |
| bus_d_o | output | 16 | Write data to the bus |
| bus_d_oe_o | output | 1 | Data output enable |
| bus_d_i | input | 16 | Read data from the bus |

## Verification
The assertions assume that the requester keeps `req_i`, address, size, direction and write data steady from the request until the acknowledge, and drops `req_i` in the cycle the acknowledge is seen. They also assume that `area_wide_i` and `large_mode_i` do not change while a request is open. The bench changes inputs only at falling edges between transactions and follows this handshake. It sweeps every area, both sizes, both directions and both address parities, and adds separate runs for the area-0 span in each mode.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_ACK
  } bus_st_e;

  typedef struct packed {
    logic use_hi;
    logic use_lo;
    logic split;
  } lane_sel_t;
endpackage

// File: rtl/ebc_area_dec.sv
module ebc_area_dec #(
  parameter int ADDR_W         = 24,
  parameter int NUM_AREAS      = 8,
  parameter int AREA_SHIFT     = 21,
  parameter int A0_SMALL_SHIFT = 17
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 large_mode_i,
  input  logic [NUM_AREAS-1:0] area_wide_i,
  output logic [NUM_AREAS-1:0] area_oh_o,
  output logic                 wide_o
);
  localparam int AREA_W = $clog2(NUM_AREAS);

  logic [AREA_W-1:0] idx;
  assign idx    = addr_i[AREA_SHIFT +: AREA_W];
  assign wide_o = area_wide_i[idx];

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    if (g == 0) begin : g_a0
      // small-address modes shrink area 0
      logic in_small;
      assign in_small     = (addr_i[AREA_SHIFT-1:A0_SMALL_SHIFT] == '0);
      assign area_oh_o[g] = (idx == AREA_W'(g)) && (large_mode_i || in_small);
    end else begin : g_an
      assign area_oh_o[g] = (idx == AREA_W'(g));
    end
  end
endmodule

// File: rtl/ebc_lane_map.sv
module ebc_lane_map
  import ebc_pkg::*;
(
  input  logic        wide_i,
  input  logic        word_i,
  input  logic        odd_i,
  input  logic        phase_i,
  input  logic [15:0] wdata_i,
  output lane_sel_t   sel_o,
  output logic [15:0] dout_o
);
  logic [7:0] byte_val;

  always_comb begin
    sel_o.split  = word_i && !wide_i;
    sel_o.use_hi = !wide_i || word_i || !odd_i;
    sel_o.use_lo = wide_i && (word_i || odd_i);
    byte_val     = (sel_o.split && !phase_i) ? wdata_i[15:8] : wdata_i[7:0];
    // unused lane simply repeats the byte
    dout_o       = (wide_i && word_i) ? wdata_i : {byte_val, byte_val};
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    split_i,
  output bus_st_e st_o,
  output logic    phase_o,
  output logic    load_o,
  output logic    cap_o
);
  bus_st_e st_q, st_d;
  logic    phase_q, phase_d;

  always_comb begin
    st_d    = st_q;
    phase_d = phase_q;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        st_d    = ST_T1;
        phase_d = 1'b0;
      end
      ST_T1: st_d = ST_T2;
      ST_T2: st_d = ST_T3;
      ST_T3: begin
        if (split_i && !phase_q) begin
          st_d    = ST_T1;
          phase_d = 1'b1;
        end else begin
          st_d = ST_ACK;
        end
      end
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
    end
  end

  assign st_o    = st_q;
  assign phase_o = phase_q;
  assign load_o  = (st_q == ST_IDLE) && req_i;
  assign cap_o   = (st_q == ST_T3);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int NUM_AREAS      = 8,
  parameter int AREA_SHIFT     = 21,
  parameter int A0_SMALL_SHIFT = 17
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  output logic                 ack_o,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 word_i,
  input  logic                 we_i,
  input  logic [15:0]          wdata_i,
  output logic [15:0]          rdata_o,
  input  logic [NUM_AREAS-1:0] area_wide_i,
  input  logic                 large_mode_i,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic [NUM_AREAS-1:0] bus_cs_no,
  output logic                 bus_rd_no,
  output logic                 bus_hwr_no,
  output logic                 bus_lwr_no,
  output logic [15:0]          bus_d_o,
  output logic                 bus_d_oe_o,
  input  logic [15:0]          bus_d_i
);
  logic [ADDR_W-1:0]    addr_q;
  logic                 word_q, we_q;
  logic [15:0]          wdata_q, rdata_q;
  logic [NUM_AREAS-1:0] area_oh;
  logic                 wide, phase, load, cap, active, strobe;
  bus_st_e              st;
  lane_sel_t            sel;
  logic [15:0]          dout;

  ebc_area_dec #(
    .ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS),
    .AREA_SHIFT(AREA_SHIFT), .A0_SMALL_SHIFT(A0_SMALL_SHIFT)
  ) u_dec (
    .addr_i(addr_q), .large_mode_i(large_mode_i), .area_wide_i(area_wide_i),
    .area_oh_o(area_oh), .wide_o(wide)
  );

  ebc_lane_map u_lane (
    .wide_i(wide), .word_i(word_q), .odd_i(addr_q[0]), .phase_i(phase),
    .wdata_i(wdata_q), .sel_o(sel), .dout_o(dout)
  );

  ebc_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .split_i(sel.split),
    .st_o(st), .phase_o(phase), .load_o(load), .cap_o(cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_i;
      word_q  <= word_i;
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (cap && !we_q) begin
      if (sel.split) begin
        if (phase) rdata_q[7:0]  <= bus_d_i[15:8];
        else       rdata_q[15:8] <= bus_d_i[15:8];
      end else if (word_q) begin
        rdata_q <= bus_d_i;
      end else begin
        rdata_q <= {8'h00, sel.use_lo ? bus_d_i[7:0] : bus_d_i[15:8]};
      end
    end
  end

  assign active = (st == ST_T1) || (st == ST_T2) || (st == ST_T3);
  assign strobe = (st == ST_T2) || (st == ST_T3);

  always_comb begin
    if (sel.split)   bus_addr_o = {addr_q[ADDR_W-1:1], phase};
    else if (word_q) bus_addr_o = {addr_q[ADDR_W-1:1], 1'b0};
    else             bus_addr_o = addr_q;
  end

  assign bus_cs_no  = active ? ~area_oh : '1;
  assign bus_rd_no  = !(strobe && !we_q);
  assign bus_hwr_no = !(strobe && we_q && sel.use_hi);
  assign bus_lwr_no = !(strobe && we_q && sel.use_lo);
  assign bus_d_o    = dout;
  assign bus_d_oe_o = active && we_q;
  assign ack_o      = (st == ST_ACK);
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int ADDR_W    = 24,
  parameter int NUM_AREAS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ack_o,
  input logic [ADDR_W-1:0]    bus_addr_o,
  input logic [NUM_AREAS-1:0] bus_cs_no,
  input logic                 bus_rd_no,
  input logic                 bus_hwr_no,
  input logic                 bus_lwr_no,
  input logic                 bus_d_oe_o
);
  a_r3_rd_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_no |-> (bus_hwr_no && bus_lwr_no));

  a_r3_rd_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_no |-> !bus_d_oe_o);

  a_r3_wr_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_hwr_no || !bus_lwr_no) |-> bus_d_oe_o);

  a_r1_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~bus_cs_no) <= 1);

  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_no || !bus_hwr_no || !bus_lwr_no) |-> $stable(bus_addr_o));

  a_r8_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r8_ack_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (bus_rd_no && bus_hwr_no && bus_lwr_no && (bus_cs_no == '1)));
endmodule

bind ext_bus_ctrl ebc_checker #(.ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .bus_addr_o(bus_addr_o),
  .bus_cs_no(bus_cs_no), .bus_rd_no(bus_rd_no), .bus_hwr_no(bus_hwr_no),
  .bus_lwr_no(bus_lwr_no), .bus_d_oe_o(bus_d_oe_o)
);

// File: tb/ext_bus_ctrl_tb_top.sv
module ext_bus_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        ack_o;
  logic [23:0] addr_i = '0;
  logic        word_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [7:0]  area_wide_i = 8'b1010_0110;
  logic        large_mode_i = 1'b1;
  logic [23:0] bus_addr_o;
  logic [7:0]  bus_cs_no;
  logic        bus_rd_no, bus_hwr_no, bus_lwr_no, bus_d_oe_o;
  logic [15:0] bus_d_o, bus_d_i;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  // bus model: each lane returns a distinct function of the address
  assign bus_d_i = {bus_addr_o[7:0] ^ 8'hA5, bus_addr_o[7:0] ^ 8'h3C};

  ext_bus_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ack_o(ack_o),
    .addr_i(addr_i), .word_i(word_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .area_wide_i(area_wide_i), .large_mode_i(large_mode_i),
    .bus_addr_o(bus_addr_o), .bus_cs_no(bus_cs_no), .bus_rd_no(bus_rd_no),
    .bus_hwr_no(bus_hwr_no), .bus_lwr_no(bus_lwr_no), .bus_d_o(bus_d_o),
    .bus_d_oe_o(bus_d_oe_o), .bus_d_i(bus_d_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] a, input logic w, input logic wr,
                      input logic [15:0] wd, input logic [7:0] exp_oh);
    logic wide, split;
    int cyc, lat, nrd, nhw, nlw, n;
    logic [23:0] ad0, ad1, a_even;
    logic [7:0] hi0, hi1, lo0;
    logic cs_bad, oe_bad;
    logic [15:0] exp_rd;
    string tag;
    wide = area_wide_i[a[23:21]];
    split = w && !wide;
    cyc = split ? 2 : 1;
    a_even = {a[23:1], 1'b0};
    tag = split ? "R7" : (wide ? (w ? "R6" : "R5") : "R4");
    lat = 0; nrd = 0; nhw = 0; nlw = 0; n = 0;
    cs_bad = 0; oe_bad = 0;
    ad0 = '0; ad1 = '0; hi0 = '0; hi1 = '0; lo0 = '0;
    @(negedge clk_i);
    addr_i = a; word_i = w; we_i = wr; wdata_i = wd; req_i = 1'b1;
    do begin
      @(negedge clk_i);
      lat++;
      if (!bus_rd_no || !bus_hwr_no || !bus_lwr_no) begin
        if (bus_cs_no != ~exp_oh) cs_bad = 1;
        if (n < 2) begin ad0 = bus_addr_o; hi0 = bus_d_o[15:8]; lo0 = bus_d_o[7:0]; end
        else begin ad1 = bus_addr_o; hi1 = bus_d_o[15:8]; end
        n++;
      end
      if (!bus_rd_no) nrd++;
      if (!bus_hwr_no) nhw++;
      if (!bus_lwr_no) nlw++;
      if (!bus_rd_no && bus_d_oe_o) oe_bad = 1;
    end while (!ack_o && lat < 20);
    chk(lat == 3 * cyc + 1, "R8 ack latency", lat, 3 * cyc + 1);
    chk(!cs_bad, "R1 chip select", {24'h0, bus_cs_no}, {24'h0, ~exp_oh});
    chk(ad0 == (w ? a_even : a), "R8 address", ad0, w ? a_even : a);
    if (split) chk(ad1 == {a[23:1], 1'b1}, "R7 second address", ad1, {a[23:1], 1'b1});
    if (!wr) begin
      chk(nrd == 2 * cyc && nhw == 0 && nlw == 0 && !oe_bad, "R3 read strobes",
          {nrd[7:0], nhw[7:0], nlw[7:0], 7'h0, oe_bad}, {8'(2 * cyc), 24'h0});
      if (split)            exp_rd = {a_even[7:0] ^ 8'hA5, (a_even[7:0] | 8'h01) ^ 8'hA5};
      else if (w)           exp_rd = {a_even[7:0] ^ 8'hA5, a_even[7:0] ^ 8'h3C};
      else if (wide && a[0]) exp_rd = {8'h00, a[7:0] ^ 8'h3C};
      else                  exp_rd = {8'h00, a[7:0] ^ 8'hA5};
      chk(rdata_o == exp_rd, "R9 read data", rdata_o, exp_rd);
    end else begin
      chk(nrd == 0 && nhw == ((!wide || w || !a[0]) ? 2 * cyc : 0) &&
          nlw == ((wide && (w || a[0])) ? 2 : 0), {tag, " write strobes"},
          {nrd[7:0], nhw[7:0], nlw[7:0]}, 0);
      if (split)
        chk(hi0 == wd[15:8] && hi1 == wd[7:0], "R7 lane data", {hi0, hi1}, wd);
      else if (wide && w)
        chk(hi0 == wd[15:8] && lo0 == wd[7:0], "R6 lane data", {hi0, lo0}, wd);
      else if (wide && a[0])
        chk(lo0 == wd[7:0], "R5 lane data", lo0, wd[7:0]);
      else
        chk(hi0 == wd[7:0], {tag, " lane data"}, hi0, wd[7:0]);
    end
    req_i = 1'b0;
    @(negedge clk_i);
    chk(bus_cs_no == 8'hFF && bus_rd_no && bus_hwr_no && bus_lwr_no,
        "R1 idle chip selects", {24'h0, bus_cs_no}, 32'hFF);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(bus_cs_no == 8'hFF && bus_rd_no && bus_hwr_no && bus_lwr_no &&
        !ack_o && !bus_d_oe_o, "R10 reset state",
        {bus_cs_no, 4'h0, bus_rd_no, bus_hwr_no, bus_lwr_no, ack_o, 7'h0, bus_d_oe_o},
        {8'hFF, 4'h0, 4'b1110, 8'h00});
    rst_ni = 1'b1;
    for (int ar = 0; ar < 8; ar++)
      for (int w = 0; w < 2; w++)
        for (int wr = 0; wr < 2; wr++)
          for (int p = 0; p < 2; p++) begin
            logic [23:0] a;
            a = {3'(ar), 21'h01_2340 + 21'(ar * 6)} | 24'(p);
            xfer(a, w[0], wr[0], {8'hD0 ^ a[7:0], 8'h1B ^ a[7:0] ^ 8'(w)},
                 8'(1 << ar));
          end
    // R2: area 0 span depends on mode
    large_mode_i = 1'b0;
    xfer(24'h03_0010, 1'b0, 1'b0, 16'h0, 8'h00);
    xfer(24'h01_0011, 1'b0, 1'b1, 16'h0077, 8'h01);
    large_mode_i = 1'b1;
    xfer(24'h03_0010, 1'b0, 1'b0, 16'h0, 8'h01);
    xfer(24'h1F_FFFE, 1'b1, 1'b1, 16'hBEEF, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule